// File: doc/BRIEF.md
# SPI Memory Slave Front End with Hold

This block is the serial front end of a memory device that is reached over SPI. It frames each transaction with the active-low chip select. It turns the serial input into parallel bytes for a command decoder, and it turns parallel read bytes from a data source into the serial output, with a separate output-enable for the tristate pad. The serial clock may idle low or high when the transaction opens, so both SPI mode 0 and SPI mode 3 work.

All four SPI pins are brought into a system clock domain through synchronisers and are oversampled. Serial clock edges are found by comparing successive synchronised samples. A hold pin can freeze a transaction mid-byte without deselecting the device. A standby indication follows chip select, but it waits for the internal busy flag of the operation engine to clear before it goes high.

Top module: `spi_mem_front`

## Requirements
- R1: A falling chip select starts a transaction. It clears the bit counter, and the first complete byte of the transaction is reported with `rx_first_o` high. Every later byte reports `rx_first_o` low.
- R2: The serial input is sampled on each rising serial clock edge, most significant bit first. After every eighth sampled bit, `rx_valid_o` pulses for one cycle with the assembled byte on `rx_byte_o`.
- R3: The serial output changes on falling serial clock edges, most significant bit first. During the first byte of a transaction it shifts out 0x00. On the falling edge that follows the eighth rising edge of a byte, `tx_byte_i` is loaded for the next byte and `tx_load_o` pulses for one cycle.
- R4: While chip select is high, `miso_oe_o` is low, and serial clock and serial input activity produce no byte.
- R5: Mode 0 (clock idle low at select) and mode 3 (clock idle high at select) give the same received bytes and the same output bits. In mode 3, a falling edge that comes before the first rising edge of a byte shifts nothing.
- R6: A hold starts only if chip select is low and the serial clock is low when the hold pin falls. A hold pin that falls while the clock is high is ignored and leaves `miso_oe_o` high.
- R7: During a hold, serial clock edges and serial input are ignored and `miso_oe_o` is low. The hold ends when the hold pin is high while the clock is low, and the byte then continues from the bit where it stopped.
- R8: If chip select rises partway through a byte, the partial byte is discarded and the next transaction starts from bit 0.
- R9: `standby_o` is high only while chip select is high and `busy_i` is low. If chip select rises while `busy_i` is high, `standby_o` stays low until `busy_i` clears.
- R10: After reset, `miso_oe_o` and `rx_valid_o` are low, and `standby_o` goes high once chip select is seen high with `busy_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold request, active low |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the serial data out pad |
| rx_byte_o | output | BYTE_W | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| rx_first_o | output | 1 | Marks the first byte of a transaction |
| tx_byte_i | input | BYTE_W | Next read byte from the data source |
| tx_load_o | output | 1 | One-cycle strobe when `tx_byte_i` is taken |
| busy_i | input | 1 | Self-timed operation in progress |
| standby_o | output | 1 | Device may enter standby |

## Verification
Multi-byte transactions are run with the clock idling low and then idling high. When the received bytes and the read bytes from both runs match, the edge handling is shown not to depend on the idle level, including the leading falling edge in mode 3. A hold is inserted after four bits of a read byte, and clock pulses with inverted data are driven during it. This tells a true freeze apart from an implementation that only gates the output enable. A hold pin that falls while the clock is high, clock activity while deselected, and a select that is dropped after three bits each check that the front end ignores input which must not count. Dropping select while busy separates deferred standby from standby that simply follows select.

// File: rtl/spi_mem_front_pkg.sv
package spi_mem_front_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic hold_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_mem_front_sync.sv
module spi_mem_front_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RST_VAL;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_mem_front_hold.sv
module spi_mem_front_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sck_s_i,
  input  logic hold_s_i,
  output logic hold_act_o
);
  logic hold_prev_q, hold_act_q;
  logic hold_fall;

  assign hold_fall = hold_prev_q & ~hold_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_prev_q <= 1'b1;
      hold_act_q  <= 1'b0;
    end else begin
      hold_prev_q <= hold_s_i;
      if (cs_s_i)                      hold_act_q <= 1'b0;
      else if (hold_fall && !sck_s_i)  hold_act_q <= 1'b1;
      else if (hold_s_i && !sck_s_i)   hold_act_q <= 1'b0;
    end
  end

  assign hold_act_o = hold_act_q;

  // R6: hold can only begin from a low clock
  p_hold_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_act_q) |-> $past(!sck_s_i && !cs_s_i));
endmodule

// File: rtl/spi_mem_front_shift.sv
module spi_mem_front_shift #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  input  logic              hold_act_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  output logic              tx_load_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              cs_prev_q, sck_prev_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] rx_sr_q;
  logic [BYTE_W-1:0] tx_sr_q, rx_byte_q;
  logic              first_q, armed_q, byte_done_q;
  logic              rx_valid_q, rx_first_q, tx_load_q, oe_q;
  logic              cs_fall, active, sck_rise, sck_fall;

  assign cs_fall  = cs_prev_q & ~cs_s_i;
  assign active   = ~cs_s_i & ~hold_act_i & ~cs_fall;
  assign sck_rise = active &  sck_s_i & ~sck_prev_q;
  assign sck_fall = active & ~sck_s_i &  sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sck_prev_q  <= 1'b0;
      bit_cnt_q   <= '0;
      rx_sr_q     <= '0;
      tx_sr_q     <= '0;
      rx_byte_q   <= '0;
      first_q     <= 1'b0;
      armed_q     <= 1'b0;
      byte_done_q <= 1'b0;
      rx_valid_q  <= 1'b0;
      rx_first_q  <= 1'b0;
      tx_load_q   <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      cs_prev_q  <= cs_s_i;
      sck_prev_q <= sck_s_i;
      rx_valid_q <= 1'b0;
      tx_load_q  <= 1'b0;
      oe_q       <= ~cs_s_i & ~hold_act_i;
      if (cs_s_i) begin
        // deselected: drop any partial byte
        bit_cnt_q   <= '0;
        armed_q     <= 1'b0;
        byte_done_q <= 1'b0;
      end else if (cs_fall) begin
        bit_cnt_q   <= '0;
        first_q     <= 1'b1;
        armed_q     <= 1'b0;
        byte_done_q <= 1'b0;
        tx_sr_q     <= '0;
      end else begin
        if (sck_rise) begin
          rx_sr_q <= {rx_sr_q[BYTE_W-3:0], mosi_s_i};
          armed_q <= 1'b1;
          if (bit_cnt_q == LAST_BIT) begin
            bit_cnt_q   <= '0;
            rx_byte_q   <= {rx_sr_q, mosi_s_i};
            rx_valid_q  <= 1'b1;
            rx_first_q  <= first_q;
            first_q     <= 1'b0;
            byte_done_q <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        // a falling edge only counts after a rising one (mode 3 lead edge)
        if (sck_fall && armed_q) begin
          armed_q <= 1'b0;
          if (byte_done_q) begin
            tx_sr_q     <= tx_byte_i;
            tx_load_q   <= 1'b1;
            byte_done_q <= 1'b0;
          end else begin
            tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign rx_byte_o  = rx_byte_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_first_o = rx_first_q;
  assign tx_load_o  = tx_load_q;
  assign miso_o     = tx_sr_q[BYTE_W-1];
  assign miso_oe_o  = oe_q;

  p_no_rx_desel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !rx_valid_o);
  p_hold_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act_i && !cs_s_i) |=> $stable(bit_cnt_q) && $stable(tx_sr_q));
  p_hold_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_act_i |=> !miso_oe_o);
  p_valid_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> bit_cnt_q == '0);
  p_load_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o);
endmodule

// File: rtl/spi_mem_front_standby.sv
module spi_mem_front_standby (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic busy_i,
  output logic standby_o
);
  logic standby_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) standby_q <= 1'b0;
    else         standby_q <= cs_s_i & ~busy_i;
  end

  assign standby_o = standby_q;

  p_standby_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !standby_o);
  p_standby_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> !standby_o);
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_mem_front_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              tx_load_o,
  input  logic              busy_i,
  output logic              standby_o
);
  localparam int PIN_W = $bits(pins_t);

  pins_t pins_raw, pins_s;
  logic  hold_act;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, mosi: mosi_i, hold_n: hold_ni};

  spi_mem_front_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_raw), .q_o(pins_s)
  );

  spi_mem_front_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_s_i(pins_s.cs_n), .sck_s_i(pins_s.sck), .hold_s_i(pins_s.hold_n),
    .hold_act_o(hold_act)
  );

  spi_mem_front_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_s_i(pins_s.cs_n), .sck_s_i(pins_s.sck), .mosi_s_i(pins_s.mosi),
    .hold_act_i(hold_act), .tx_byte_i(tx_byte_i),
    .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o), .rx_first_o(rx_first_o),
    .tx_load_o(tx_load_o), .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );

  spi_mem_front_standby u_standby (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_s_i(pins_s.cs_n), .busy_i(busy_i), .standby_o(standby_o)
  );
endmodule

// File: tb/spi_mem_front_test.sv
module spi_mem_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, mosi_i = 1'b0, hold_ni = 1'b1, busy_i = 1'b0;
  logic miso_o, miso_oe_o, rx_valid_o, rx_first_o, tx_load_o, standby_o;
  logic [7:0] rx_byte_o, tx_byte_i;
  logic [7:0] tx_cnt = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit first_byte;
  logic [8:0] rx_q[$];
  logic [7:0] tx_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign tx_byte_i = 8'hC3 ^ (tx_cnt * 8'h1D);

  spi_mem_front uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .mosi_i(mosi_i),
    .hold_ni(hold_ni), .miso_o(miso_o), .miso_oe_o(miso_oe_o), .rx_byte_o(rx_byte_o),
    .rx_valid_o(rx_valid_o), .rx_first_o(rx_first_o), .tx_byte_i(tx_byte_i),
    .tx_load_o(tx_load_o), .busy_i(busy_i), .standby_o(standby_o)
  );

  always @(posedge clk_i) if (tx_load_o) tx_cnt <= tx_cnt + 8'd1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: received bytes and source loads
  always @(negedge clk_i) begin
    if (rst_ni && tx_load_o) tx_q.push_back(tx_byte_i);
    if (rst_ni && rx_valid_o) begin
      if (rx_q.size() == 0) check("R4/R8 unexpected byte", {rx_first_o, rx_byte_o}, 9'h1FF);
      else check("R1/R2 rx byte", {rx_first_o, rx_byte_o}, rx_q.pop_front());
    end
  end

  task automatic wait_hp();
    repeat (HP) @(negedge clk_i);
  endtask

  task automatic sel(input bit mode3);
    sck_i = mode3;
    wait_hp();
    cs_ni = 1'b0;
    first_byte = 1;
    wait_hp();
  endtask

  task automatic desel();
    wait_hp();
    cs_ni = 1'b1;
    wait_hp();
    check("R4 oe off when deselected", miso_oe_o, 1'b0);
    tx_q.delete();
  endtask

  // hold_kind: 0 none, 1 proper hold before bit hold_at, 2 hold pin drop with clock high at bit hold_at
  task automatic xfer(input bit mode3, input logic [7:0] b, input int nbits,
                      input int hold_kind, input int hold_at);
    logic [7:0] got = '0;
    logic [7:0] exp;
    if (nbits == 8) rx_q.push_back({first_byte, b});
    for (int i = 0; i < nbits; i++) begin
      if (hold_kind == 1 && i == hold_at) begin
        wait_hp();
        hold_ni = 1'b0;
        wait_hp();
        check("R7 oe low in hold", miso_oe_o, 1'b0);
        for (int k = 0; k < 3; k++) begin
          mosi_i = ~b[7-i];
          sck_i = 1'b1; wait_hp();
          sck_i = 1'b0; wait_hp();
        end
        hold_ni = 1'b1;
        wait_hp();
        check("R7 oe back after hold", miso_oe_o, 1'b1);
      end
      if (mode3) sck_i = 1'b0;
      mosi_i = b[7-i];
      wait_hp();
      got[7-i] = miso_o;
      sck_i = 1'b1;
      wait_hp();
      if (hold_kind == 2 && i == hold_at) begin
        hold_ni = 1'b0;
        wait_hp();
        check("R6 hold ignored with clock high", miso_oe_o, 1'b1);
        sck_i = 1'b0;
        wait_hp();
        check("R6 still no hold", miso_oe_o, 1'b1);
        hold_ni = 1'b1;
        wait_hp();
      end else if (!mode3) begin
        sck_i = 1'b0;
      end
    end
    if (nbits == 8) begin
      if (first_byte) exp = 8'h00;
      else if (tx_q.size() == 0) begin
        check("R3 tx load missing", 1'b0, 1'b1);
        exp = 8'hxx;
      end else exp = tx_q.pop_front();
      check(mode3 ? "R5 R3 read byte mode 3" : "R3 read byte mode 0", got, exp);
      first_byte = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    check("R10 oe at reset", miso_oe_o, 1'b0);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    check("R10 oe after reset", miso_oe_o, 1'b0);
    check("R10 no strobe", rx_valid_o, 1'b0);
    check("R10 standby", standby_o, 1'b1);

    // mode 0 framing
    sel(0);
    check("R9 no standby while selected", standby_o, 1'b0);
    check("R1 oe on when selected", miso_oe_o, 1'b1);
    xfer(0, 8'h9F, 8, 0, 0);
    xfer(0, 8'hA5, 8, 0, 0);
    xfer(0, 8'h3C, 8, 0, 0);
    desel();

    // mode 3 framing
    sel(1);
    xfer(1, 8'h0B, 8, 0, 0);
    xfer(1, 8'h5A, 8, 0, 0);
    xfer(1, 8'hC7, 8, 0, 0);
    desel();

    // R4: clock activity while deselected
    for (int k = 0; k < 9; k++) begin
      mosi_i = k[0];
      sck_i = 1'b1; wait_hp();
      sck_i = 1'b0; wait_hp();
      check("R4 oe off, no byte", miso_oe_o, 1'b0);
    end

    // R7: hold in the middle of a read byte
    sel(0);
    xfer(0, 8'h02, 8, 0, 0);
    xfer(0, 8'hB6, 8, 1, 4);
    xfer(0, 8'h4D, 8, 0, 0);
    desel();

    // R6: hold pin dropping with clock high is ignored
    sel(0);
    xfer(0, 8'h6E, 8, 2, 2);
    xfer(0, 8'h91, 8, 2, 5);
    desel();

    // R8: partial byte discarded
    sel(0);
    xfer(0, 8'hFF, 3, 0, 0);
    desel();
    sel(0);
    xfer(0, 8'h71, 8, 0, 0);
    desel();

    // R9: deselect while busy
    busy_i = 1'b1;
    sel(1);
    xfer(1, 8'hD8, 8, 0, 0);
    desel();
    check("R9 standby deferred while busy", standby_o, 1'b0);
    wait_hp();
    check("R9 standby still deferred", standby_o, 1'b0);
    busy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9 standby after busy clears", standby_o, 1'b1);

    wait_hp();
    check("R2 all expected bytes seen", rx_q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule